// File: doc/BRIEF.md
# Dual-Rail Stall Gate for a Self-Timed Decode Stage

This block guards one control bit of a decoded instruction on its way out of the decode stage of a four-phase, return-to-zero dual-rail pipeline. A dual-rail select says whether the current instruction depends on the one ahead of it. An independent instruction goes through a router and a merge to the output at once. A dependent instruction goes into a pair of state-holding completion gates, one per rail. These gates release the bit only once the write-back stage raises its single-rail acknowledge. Only this one bit is gated. While it stays NULL, the completion logic downstream cannot finish, so the rest of the word waits with it.

The completion gates are modelled as clocked state-holding elements. Each one sets when all of its inputs are high and clears when all of them are low; otherwise it keeps its value. An asynchronous active-low reset clears both gates. A status-read request goes out while a released dependent value sits on the stall path, so that branch resolution can read the flags. A sticky error flag records any illegal code seen on an input pair.

Top module: `dr_stall_gate`

## Requirements
- R1: After reset, the output pair reads NULL, the status-read request is low and the error flag is low.
- R2: Each dual-rail pair (t,f) uses this code: (0,0) is NULL, (0,1) is a valid 0, (1,0) is a valid 1, and (1,1) is illegal.
- R3: When the select is a valid 0 (bypass), the output equals the opcode pair in the same cycle, whatever the acknowledge is.
- R4: When the select is a valid 1 (stall), the output stays NULL at every clock edge at which the acknowledge is low.
- R5: On the stall path, a valid opcode sampled together with a high acknowledge at a clock edge appears on the output from that edge on.
- R6: A released stall value holds until a clock edge sees both the stall-path input NULL and the acknowledge low. From that edge on, the output is NULL.
- R7: The status-read request is high exactly while the stall path holds a valid value.
- R8: A (1,1) code on the opcode pair or the select pair sets the error flag at the next clock edge. The flag stays set until reset.
- R9: When the select pair is NULL, the opcode is routed to neither path, and the output stays NULL unless the stall path already holds a value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock that samples the completion gates |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_t_i | input | 1 | True rail of the gated opcode bit |
| op_f_i | input | 1 | False rail of the gated opcode bit |
| sel_t_i | input | 1 | True rail of the select (1 = stall) |
| sel_f_i | input | 1 | False rail of the select (0 = bypass) |
| wb_ack_i | input | 1 | Single-rail completion acknowledge from write-back |
| out_t_o | output | 1 | True rail of the forwarded bit |
| out_f_o | output | 1 | False rail of the forwarded bit |
| stat_rd_o | output | 1 | Status-read request for branch resolution |
| proto_err_o | output | 1 | Sticky illegal-code flag |

## Verification
The bench goes after a dependent value that waits through several cycles of low acknowledge. A gate that leaks would show a valid output before write-back completes. It holds the acknowledge high after the opcode returns to NULL, to catch a gate that clears early and breaks return-to-zero. It checks that a bypassed value ignores the acknowledge level, which a wrongly wired router would tie to write-back. It drives illegal codes and then legal traffic, so that an error flag that is not sticky, or never sets, shows at the port.

// File: rtl/dr_stall_pkg.sv
package dr_stall_pkg;
  localparam int unsigned RAILS = 2;   // index 1 = true rail, 0 = false rail
  localparam int unsigned RAIL_T = 1;
  localparam int unsigned RAIL_F = 0;

  typedef logic [RAILS-1:0] dr_bit_t;

  localparam dr_bit_t DR_NULL = 2'b00;
  localparam dr_bit_t DR_V0   = 2'b01;
  localparam dr_bit_t DR_V1   = 2'b10;

  function automatic logic dr_valid(dr_bit_t b);
    return b[RAIL_T] ^ b[RAIL_F];
  endfunction

  function automatic logic dr_illegal(dr_bit_t b);
    return b[RAIL_T] & b[RAIL_F];
  endfunction
endpackage

// File: rtl/dr_celem.sv
module dr_celem #(
  parameter int unsigned N_IN = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] in_i,
  output logic            out_o
);
  logic all_hi, all_lo;
  assign all_hi = &in_i;
  assign all_lo = ~|in_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     out_o <= 1'b0;
    else if (all_hi) out_o <= 1'b1;
    else if (all_lo) out_o <= 1'b0;
  end

  AST_CEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(all_hi) && !$past(all_lo)) |-> $stable(out_o)); // R6
endmodule

// File: rtl/dr_route.sv
module dr_route
  import dr_stall_pkg::*;
(
  input  dr_bit_t op_i,
  input  dr_bit_t sel_i,
  output dr_bit_t byp_o,
  output dr_bit_t stl_o
);
  for (genvar r = 0; r < RAILS; r++) begin : g_rail
    assign byp_o[r] = op_i[r] & sel_i[RAIL_F];
    assign stl_o[r] = op_i[r] & sel_i[RAIL_T];
  end
endmodule

// File: rtl/dr_proto_mon.sv
module dr_proto_mon
  import dr_stall_pkg::*;
#(
  parameter int unsigned N_PAIR = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_PAIR*RAILS-1:0] pairs_i,
  output logic                    err_o
);
  logic [N_PAIR-1:0] bad;
  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    assign bad[p] = dr_illegal(pairs_i[p*RAILS +: RAILS]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  err_o <= 1'b0;
    else if (|bad) err_o <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R8
  AST_ERR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bad) |=> err_o); // R8
endmodule

// File: rtl/dr_stall_gate.sv
module dr_stall_gate
  import dr_stall_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic op_t_i,
  input  logic op_f_i,
  input  logic sel_t_i,
  input  logic sel_f_i,
  input  logic wb_ack_i,
  output logic out_t_o,
  output logic out_f_o,
  output logic stat_rd_o,
  output logic proto_err_o
);
  dr_bit_t op, sel, byp, stl, held, out;

  assign op  = {op_t_i, op_f_i};
  assign sel = {sel_t_i, sel_f_i};

  dr_route u_route (
    .op_i  (op),
    .sel_i (sel),
    .byp_o (byp),
    .stl_o (stl)
  );

  // one completion gate per rail, joined with the write-back acknowledge
  for (genvar r = 0; r < RAILS; r++) begin : g_gate
    dr_celem #(.N_IN(2)) u_cel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   ({wb_ack_i, stl[r]}),
      .out_o  (held[r])
    );
  end

  // merge
  assign out       = byp | held;
  assign out_t_o   = out[RAIL_T];
  assign out_f_o   = out[RAIL_F];
  assign stat_rd_o = |held;

  dr_proto_mon #(.N_PAIR(2)) u_mon (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pairs_i ({op, sel}),
    .err_o   (proto_err_o)
  );

  AST_RELEASE_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|held) |-> $past(wb_ack_i)); // R5
  AST_RTZ_NEEDS_ACK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|held) |-> !$past(wb_ack_i)); // R6
  AST_BYPASS_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == DR_V0 && dr_valid(op) && !(|held)) |-> (out == op)); // R3
  AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sel) == DR_V1 && !$past(wb_ack_i) && !$past(|held)) |-> !(|held)); // R4
endmodule

// File: tb/sim_dr_stall_gate.sv
module sim_dr_stall_gate;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic op_t = 0, op_f = 0, sel_t = 0, sel_f = 0, ack = 0;
  logic out_t, out_f, stat_rd, err;
  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  int m_st_t = 0, m_st_f = 0, m_err = 0;

  always #10 clk = ~clk;

  dr_stall_gate u0 (
    .clk_i(clk), .rst_ni(rst_ni), .op_t_i(op_t), .op_f_i(op_f),
    .sel_t_i(sel_t), .sel_f_i(sel_f), .wb_ack_i(ack),
    .out_t_o(out_t), .out_f_o(out_f), .stat_rd_o(stat_rd), .proto_err_o(err)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare, then advance model at posedge
  task automatic step(string req, int ot, int of_, int st, int sf, int a);
    int ex_t, ex_f, ex_s;
    @(negedge clk);
    op_t = 1'(ot); op_f = 1'(of_); sel_t = 1'(st); sel_f = 1'(sf); ack = 1'(a);
    #1;
    ex_t = (ot & sf) | m_st_t;
    ex_f = (of_ & sf) | m_st_f;
    ex_s = m_st_t | m_st_f;
    chk({req, " out"}, {30'd0, out_t, out_f}, ex_t * 2 + ex_f);
    chk("R7 stat_rd", int'(stat_rd), ex_s);
    chk("R8 err", int'(err), m_err);
    @(posedge clk);
    if ((ot & st) && a) m_st_t = 1; else if (!(ot & st) && !a) m_st_t = 0;
    if ((of_ & st) && a) m_st_f = 1; else if (!(of_ & st) && !a) m_st_f = 0;
    if ((ot & of_) || (st & sf)) m_err = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; op_t = 0; op_f = 0; sel_t = 0; sel_f = 0; ack = 0;
    m_st_t = 0; m_st_f = 0; m_err = 0;
    #1;
    chk("R1 out_t", int'(out_t), 0);
    chk("R1 out_f", int'(out_f), 0);
    chk("R1 stat_rd", int'(stat_rd), 0);
    chk("R1 err", int'(err), 0);
    @(negedge clk);
    rst_ni = 1;
  endtask

  initial begin
    do_reset();
    // R3 bypass ignores ack, R2 codes
    step("R3 byp v1 ack0", 1, 0, 0, 1, 0);
    step("R2 rtz", 0, 0, 0, 0, 0);
    step("R3 byp v0 ack1", 0, 1, 0, 1, 1);
    step("R2 rtz", 0, 0, 0, 0, 0);
    // R9 select NULL routes nothing
    step("R9 sel null", 1, 0, 0, 0, 1);
    step("R9 sel null", 0, 1, 0, 0, 0);
    step("R2 rtz", 0, 0, 0, 0, 0);
    // R4 stall waits, R5 release
    for (int i = 0; i < 4; i++) step("R4 stall v1", 1, 0, 1, 0, 0);
    step("R5 ack rises", 1, 0, 1, 0, 1);
    step("R5 released", 1, 0, 1, 0, 1);
    // R6 hold while ack stays high after input NULL
    step("R6 hold", 0, 0, 0, 0, 1);
    step("R6 hold", 0, 0, 0, 0, 1);
    step("R6 rtz", 0, 0, 0, 0, 0);
    step("R6 null", 0, 0, 0, 0, 0);
    // stall valid 0
    for (int i = 0; i < 3; i++) step("R4 stall v0", 0, 1, 1, 0, 0);
    step("R5 ack v0", 0, 1, 1, 0, 1);
    step("R6 hold v0", 0, 1, 1, 0, 0);
    step("R6 rtz v0", 0, 0, 1, 0, 0);
    step("R6 null", 0, 0, 0, 0, 0);
    // ack high before arrival: releases at first edge
    step("R5 early ack", 0, 0, 1, 0, 1);
    step("R5 early ack", 1, 0, 1, 0, 1);
    step("R5 held", 0, 0, 0, 0, 1);
    step("R6 rtz", 0, 0, 0, 0, 0);
    step("R2 null", 0, 0, 0, 0, 0);
    // R8 illegal opcode then legal traffic
    step("R8 bad op", 1, 1, 0, 0, 0);
    step("R8 sticky", 0, 0, 0, 0, 0);
    step("R8 sticky byp", 1, 0, 0, 1, 0);
    step("R8 sticky", 0, 0, 0, 0, 0);
    do_reset();
    step("R8 cleared", 0, 0, 0, 0, 0);
    step("R8 bad sel", 0, 0, 1, 1, 0);
    step("R8 sticky", 0, 0, 0, 0, 0);
    step("R8 sticky", 0, 0, 0, 0, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule